// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Engine

This block keeps the register set of a PCI message-signalled interrupt capability and turns internal interrupt request pulses into memory-write messages. Configuration software reaches the registers through a dword-addressed read/write port with byte enables. The port address counts dwords from the start of the capability. Device logic raises one pulse per vector on `irq_req`. The block then presents one message at a time on a valid/ready handshake: a 64-bit target address and a 32-bit data word.

Software can mask vectors one by one. A vector requested while masked is latched as pending and is sent later, when a configuration write unmasks it. If software enables more vectors than the function can use, the enabled count is clamped to the capable count. The vector number is folded into the low bits of the data word. A legacy level-interrupt input is passed through to `intx_o` only while message signalling is disabled.

Build parameters choose the capable vector count (`CAP_LOG2`), whether the upper address register exists (`ADDR64`) and whether the mask and pending registers exist (`PVMASK`). These parameters set both the capability length and the register offsets.

Top module: `msi_engine`

## Requirements
- R1: After reset, the enable bit and the enabled-count field read 0. The address, data, mask and pending registers read 0. `msg_valid` and `intx_o` are low. The capable-count field and the two feature bits keep their build values.
- R2: Dword 0 reads as {control[15:0], 8'h00, 8'h05}. Control bits: bit 0 is the enable bit, [3:1] is the capable log2 count, [6:4] is the enabled log2 count, bit 7 is the 64-bit flag, bit 8 is the mask flag. With `ADDR64`=1 the dwords are: 1 lower address, 2 upper address, 3 data, 4 mask, 5 pending. With `ADDR64`=0 the data register is at dword 2 and the others follow it. Dwords past the capability read 0.
- R3: In the control word, only the enable bit and the enabled-count field can be written, both through byte lane 2. Lower address bits 1:0 always read 0. The upper address register is fully writable. Only the low 16 bits of the data register exist.
- R4: Only mask bits 0 to N-1 can be written, where N = 2^CAP_LOG2. Writes to the pending register have no effect.
- R5: After a configuration write to the capability that leaves enable set, an enabled-count field above the capable field reads back as the capable value.
- R6: After such a write, pending bits at or above the enabled vector count are cleared.
- R7: A request is ignored while enable is clear, and also for a vector at or above the enabled count. An ignored request sends no message and sets no pending bit.
- R8: A request to a masked vector sets its pending bit and sends no message. Without `PVMASK`, no vector is treated as masked.
- R9: After such a write, every vector below the enabled count that is pending and unmasked has its pending bit cleared and its message sent, lowest vector first.
- R10: A message carries {upper, lower} address (upper is 0 without `ADDR64`). Its data is the programmed data with the low log2(enabled count) bits replaced by the vector number, and bits 31:16 are zero. Address and data hold steady while valid is high and ready is low.
- R11: Only one message is outstanding at a time. Waiting vectors are issued one per handshake, lowest first. A request for the vector that is already outstanding adds no further message.
- R12: `intx_o` follows `intx_req` one cycle later while enable is clear, and stays low while enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Dword index within the capability |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| irq_req | input | 2^CAP_LOG2 | Per-vector request pulses |
| intx_req | input | 1 | Legacy level interrupt request |
| intx_o | output | 1 | Legacy interrupt output |
| msg_valid | output | 1 | Message presented |
| msg_ready | input | 1 | Message accepted when high with valid |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
Some properties are checked by assertions on every cycle. A message holds steady until it is accepted, and its upper data half is zero. No queued vector is masked. While enabled, no pending bit sits at or above the enabled count. At most one vector is granted at a time. `intx_o` stays low while enable is set. Other behaviour can only be shown by the bench scenarios. These scenarios cover the data folding for every enabled count and vector, the clamping, the replay order after an unmasking write, the merging of a duplicate request, and the write masks seen on read-back.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam logic [7:0] CAP_ID = 8'h05;
  localparam int CTL_EN  = 0;
  localparam int CTL_CAP = 1;
  localparam int CTL_ENC = 4;
  localparam int CTL_A64 = 7;
  localparam int CTL_PVM = 8;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msi_msg_t;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter int CAP_LOG2 = 3,
  parameter bit ADDR64   = 1'b1,
  parameter bit PVMASK   = 1'b1,
  localparam int NV      = 1 << CAP_LOG2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_addr,
  input  logic [3:0]    cfg_be,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [NV-1:0] irq_req,
  input  logic [NV-1:0] take,
  input  logic [NV-1:0] busy,
  output logic          en_o,
  output logic [2:0]    cnt_o,
  output logic [63:0]   addr_o,
  output logic [15:0]   data_o,
  output logic [NV-1:0] work_o
);
  localparam int A_LO  = 1;
  localparam int A_HI  = 2;
  localparam int A_DAT = ADDR64 ? 3 : 2;
  localparam int A_MSK = A_DAT + 1;
  localparam int A_PND = A_DAT + 2;
  localparam int NDW   = PVMASK ? A_PND + 1 : A_DAT + 1;

  function automatic logic [NV-1:0] below(input logic [2:0] lg);
    logic [NV-1:0] r;
    for (int i = 0; i < NV; i++) r[i] = (i < (1 << lg));
    return r;
  endfunction

  logic          en_q, en_n;
  logic [2:0]    enc_q, enc_n;
  logic [31:0]   alo_q, alo_n, ahi_q, ahi_n;
  logic [15:0]   dat_q, dat_n;
  logic [NV-1:0] mask_q, mask_n, pend_q, pend_n, work_q, work_n;
  logic [NV-1:0] mask_eff_q, mask_eff_n, below_n, below_q;
  logic [NV-1:0] pend_t, replay, req_ok;
  logic          touch;

  assign touch      = cfg_wr && (cfg_addr < 3'(NDW));
  assign mask_eff_q = PVMASK ? mask_q : '0;
  assign below_q    = below(enc_q);

  always_comb begin
    en_n   = en_q;
    enc_n  = enc_q;
    alo_n  = alo_q;
    ahi_n  = ahi_q;
    dat_n  = dat_q;
    mask_n = mask_q;
    if (cfg_wr && cfg_addr == 3'd0 && cfg_be[2]) begin
      en_n  = cfg_wdata[16 + CTL_EN];
      enc_n = cfg_wdata[16 + CTL_ENC +: 3];
    end
    if (cfg_wr && cfg_addr == 3'(A_LO)) begin
      for (int b = 0; b < 4; b++)
        if (cfg_be[b]) alo_n[8*b +: 8] = cfg_wdata[8*b +: 8];
      alo_n[1:0] = 2'b00;
    end
    if (ADDR64 && cfg_wr && cfg_addr == 3'(A_HI)) begin
      for (int b = 0; b < 4; b++)
        if (cfg_be[b]) ahi_n[8*b +: 8] = cfg_wdata[8*b +: 8];
    end
    if (cfg_wr && cfg_addr == 3'(A_DAT)) begin
      if (cfg_be[0]) dat_n[7:0]  = cfg_wdata[7:0];
      if (cfg_be[1]) dat_n[15:8] = cfg_wdata[15:8];
    end
    if (PVMASK && cfg_wr && cfg_addr == 3'(A_MSK)) begin
      for (int i = 0; i < NV; i++)
        if (cfg_be[i/8]) mask_n[i] = cfg_wdata[i];
    end
    if (touch && en_n && enc_n > 3'(CAP_LOG2)) enc_n = 3'(CAP_LOG2);
  end

  assign mask_eff_n = PVMASK ? mask_n : '0;
  assign below_n    = below(enc_n);

  always_comb begin
    pend_n = pend_q;
    work_n = work_q & ~take;
    pend_t = pend_q & below_n;
    replay = pend_t & ~mask_eff_n;
    if (touch && en_n) begin
      pend_n = pend_t & ~replay;
      work_n = work_n | replay;
    end
    req_ok = irq_req & below_n & {NV{en_n}} & ~busy & ~take;
    pend_n = pend_n | (req_ok & mask_eff_n);
    work_n = work_n | (req_ok & ~mask_eff_n);
    if (en_n) pend_n = pend_n | (work_n & mask_eff_n & below_n);
    work_n = work_n & ~mask_eff_n & below_n & {NV{en_n}};
    if (!PVMASK) pend_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      enc_q  <= 3'd0;
      alo_q  <= '0;
      ahi_q  <= '0;
      dat_q  <= '0;
      mask_q <= '0;
      pend_q <= '0;
      work_q <= '0;
    end else begin
      en_q   <= en_n;
      enc_q  <= enc_n;
      alo_q  <= alo_n;
      ahi_q  <= ADDR64 ? ahi_n : 32'd0;
      dat_q  <= dat_n;
      mask_q <= mask_n;
      pend_q <= pend_n;
      work_q <= work_n;
    end
  end

  logic [15:0] ctl_word;
  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_EN]        = en_q;
    ctl_word[CTL_CAP +: 3]  = 3'(CAP_LOG2);
    ctl_word[CTL_ENC +: 3]  = enc_q;
    ctl_word[CTL_A64]       = ADDR64;
    ctl_word[CTL_PVM]       = PVMASK;
    cfg_rdata = '0;
    if (cfg_addr == 3'd0)                  cfg_rdata = {ctl_word, 8'h00, CAP_ID};
    else if (cfg_addr == 3'(A_LO))         cfg_rdata = alo_q;
    else if (ADDR64 && cfg_addr == 3'(A_HI)) cfg_rdata = ahi_q;
    else if (cfg_addr == 3'(A_DAT))        cfg_rdata = {16'h0, dat_q};
    else if (PVMASK && cfg_addr == 3'(A_MSK)) cfg_rdata = 32'(mask_q);
    else if (PVMASK && cfg_addr == 3'(A_PND)) cfg_rdata = 32'(pend_q);
  end

  assign en_o   = en_q;
  assign cnt_o  = enc_q;
  assign addr_o = {ahi_q, alo_q};
  assign data_o = dat_q;
  assign work_o = work_q;

  p_work_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (work_q & mask_eff_q) == '0);
  p_pend_below_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> ((pend_q & ~below_q) == '0));
endmodule

// File: rtl/msi_pick.sv
module msi_pick #(
  parameter int NV = 8,
  parameter int VW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NV-1:0] work,
  output logic [NV-1:0] grant,
  output logic          any,
  output logic [VW-1:0] idx
);
  assign grant = work & (~work + NV'(1));
  assign any   = |work;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NV; i++)
      if (grant[i]) idx = VW'(i);
  end

  p_single_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out
  import msi_pkg::*;
#(
  parameter int NV = 8,
  parameter int VW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any,
  input  logic [NV-1:0] grant,
  input  logic [VW-1:0] idx,
  input  logic [63:0]   addr_in,
  input  logic [15:0]   data_in,
  input  logic [2:0]    cnt,
  input  logic          ready,
  output logic          valid,
  output msi_msg_t      msg,
  output logic [NV-1:0] take,
  output logic [NV-1:0] busy
);
  logic          valid_q, valid_n, load;
  logic [VW-1:0] vec_q, vec_n;
  msi_msg_t      msg_q, msg_n;
  logic [15:0]   lowm, vec16;

  assign load  = any && (!valid_q || ready);
  assign take  = load ? grant : '0;
  assign lowm  = (16'h1 << cnt) - 16'h1;
  assign vec16 = 16'(idx);

  always_comb begin
    valid_n = valid_q;
    vec_n   = vec_q;
    msg_n   = msg_q;
    if (valid_q && ready) valid_n = 1'b0;
    if (load) begin
      valid_n    = 1'b1;
      vec_n      = idx;
      msg_n.addr = addr_in;
      msg_n.data = {16'h0, (data_in & ~lowm) | (vec16 & lowm)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      msg_q   <= '0;
    end else begin
      valid_q <= valid_n;
      if (load) begin
        vec_q <= vec_n;
        msg_q <= msg_n;
      end
    end
  end

  assign valid = valid_q;
  assign msg   = msg_q;
  assign busy  = valid_q ? (NV'(1) << vec_q) : '0;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready) |=> (valid_q && $stable(msg_q)));
  p_data_hi_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (msg_q.data[31:16] == 16'h0));
endmodule

// File: rtl/msi_engine.sv
module msi_engine
  import msi_pkg::*;
#(
  parameter int CAP_LOG2 = 3,
  parameter bit ADDR64   = 1'b1,
  parameter bit PVMASK   = 1'b1,
  localparam int NV      = 1 << CAP_LOG2,
  localparam int VW      = (CAP_LOG2 > 0) ? CAP_LOG2 : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_addr,
  input  logic [3:0]    cfg_be,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [NV-1:0] irq_req,
  input  logic          intx_req,
  output logic          intx_o,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [63:0]   msg_addr,
  output logic [31:0]   msg_data
);
  logic [1:0]    rsync_q;
  logic          rst_s;
  logic          en;
  logic [2:0]    cnt;
  logic [63:0]   base_addr;
  logic [15:0]   base_data;
  logic [NV-1:0] work, grant, take, busy;
  logic          any;
  logic [VW-1:0] idx;
  msi_msg_t      msg;
  logic          intx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  msi_cfg_regs #(.CAP_LOG2(CAP_LOG2), .ADDR64(ADDR64), .PVMASK(PVMASK)) u_regs (
    .clk(clk), .rst_n(rst_s), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_req(irq_req), .take(take), .busy(busy), .en_o(en), .cnt_o(cnt),
    .addr_o(base_addr), .data_o(base_data), .work_o(work)
  );

  msi_pick #(.NV(NV), .VW(VW)) u_pick (
    .clk(clk), .rst_n(rst_s), .work(work), .grant(grant), .any(any), .idx(idx)
  );

  msi_msg_out #(.NV(NV), .VW(VW)) u_out (
    .clk(clk), .rst_n(rst_s), .any(any), .grant(grant), .idx(idx),
    .addr_in(base_addr), .data_in(base_data), .cnt(cnt), .ready(msg_ready),
    .valid(msg_valid), .msg(msg), .take(take), .busy(busy)
  );

  assign msg_addr = msg.addr;
  assign msg_data = msg.data;

  logic en_next;
  assign en_next = (cfg_wr && cfg_addr == 3'd0 && cfg_be[2]) ? cfg_wdata[16] : en;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) intx_q <= 1'b0;
    else        intx_q <= intx_req && !en_next;
  end
  assign intx_o = intx_q;

  p_intx_quiet_r12: assert property (@(posedge clk) disable iff (!rst_s)
    en |-> !intx_o);
endmodule

// File: tb/sim_msi_engine.sv
module sim_msi_engine;
  localparam int CL = 2;
  localparam int NV = 1 << CL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [2:0]    cfg_addr = 3'd0;
  logic [3:0]    cfg_be = 4'h0;
  logic [31:0]   cfg_wdata = 32'h0;
  logic [31:0]   cfg_rdata;
  logic [NV-1:0] irq_req = '0;
  logic          intx_req = 1'b0;
  logic          intx_o;
  logic          msg_valid;
  logic          msg_ready = 1'b0;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  msi_engine #(.CAP_LOG2(CL), .ADDR64(1'b1), .PVMASK(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_req(irq_req), .intx_req(intx_req), .intx_o(intx_o),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  always #5 clk = ~clk;

  localparam logic [31:0] A_LO = 32'h1000_0043;
  localparam logic [31:0] A_HI = 32'h0000_00A5;
  localparam logic [63:0] EXP_ADDR = {A_HI, 32'h1000_0040};

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic pulse(input logic [NV-1:0] v);
    @(negedge clk);
    irq_req = v;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic ctl(input int mme);
    wr(3'd0, 4'b0100, 32'(1 | (mme << 4)) << 16);
  endtask

  task automatic expect_msg(input int vec, input logic [31:0] ed, input string req);
    int n = 0;
    while (!msg_valid && n < 30) begin @(negedge clk); n++; end
    chk(msg_valid, req, 64'(msg_valid), 64'd1);
    chk(msg_addr == EXP_ADDR, req, msg_addr, EXP_ADDR);
    chk(msg_data == ed, req, 64'(msg_data), 64'(ed));
    @(negedge clk); @(negedge clk);
    chk(msg_valid && msg_data == ed, {req, " hold vec ", $sformatf("%0d", vec)}, 64'(msg_data), 64'(ed));
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic expect_none(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk(!seen, req, 64'(seen), 64'd0);
  endtask

  logic [31:0] r;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2: reset values and layout (capable 2, 64-bit, mask)
    rd(3'd0, r); chk(r == 32'h0184_0005, "R1 R2 ctrl", 64'(r), 64'h0184_0005);
    for (int a = 1; a <= 7; a++) begin
      rd(3'(a), r); chk(r == 0, "R1 R2 regs zero", 64'(r), 0);
    end
    chk(!msg_valid && !intx_o, "R1 outputs", 64'({msg_valid, intx_o}), 0);

    // R12: INTx passes while disabled
    @(negedge clk); intx_req = 1'b1;
    @(negedge clk); #1 chk(intx_o, "R12 intx pass", 64'(intx_o), 1);

    // R7: disabled request ignored
    pulse(4'b1111);
    expect_none("R7 disabled");
    rd(3'd5, r); chk(r == 0, "R7 no pending", 64'(r), 0);

    // R3 R5: write all ones; clamp and write masks
    wr(3'd0, 4'b1111, 32'hFFFF_FFFF);
    rd(3'd0, r); chk(r == 32'h01A5_0005, "R3 R5 ctrl clamp", 64'(r), 64'h01A5_0005);
    @(negedge clk); chk(!intx_o, "R12 intx low enabled", 64'(intx_o), 0);
    wr(3'd1, 4'b1111, 32'hFFFF_FFFF);
    rd(3'd1, r); chk(r == 32'hFFFF_FFFC, "R3 addr lo", 64'(r), 64'hFFFF_FFFC);
    wr(3'd3, 4'b1111, 32'h1234_ABCD);
    rd(3'd3, r); chk(r == 32'h0000_ABCD, "R3 data", 64'(r), 64'hABCD);
    wr(3'd4, 4'b1111, 32'hFFFF_FFFF);
    rd(3'd4, r); chk(r == 32'hF, "R4 mask bits", 64'(r), 64'hF);
    wr(3'd5, 4'b1111, 32'hFFFF_FFFF);
    rd(3'd5, r); chk(r == 0, "R4 pending ro", 64'(r), 0);

    wr(3'd1, 4'b1111, A_LO);
    wr(3'd2, 4'b1111, A_HI);
    rd(3'd2, r); chk(r == A_HI, "R3 addr hi", 64'(r), 64'(A_HI));
    wr(3'd3, 4'b0011, 32'h0000_BEEF);
    wr(3'd4, 4'b1111, 32'h0);

    // R10 R7: sweep enabled counts and vectors
    for (int m = 0; m <= CL; m++) begin
      ctl(m);
      for (int v = 0; v < NV; v++) begin
        pulse(NV'(1) << v);
        if (v < (1 << m)) begin
          logic [31:0] lm;
          lm = (32'd1 << m) - 1;
          expect_msg(v, (32'hBEEF & ~lm) | 32'(v), "R10 fold");
        end else begin
          expect_none("R7 above count");
          rd(3'd5, r); chk(r == 0, "R7 above count pending", 64'(r), 0);
        end
      end
    end

    // R8 R9: masked capture then unmask replays 1 then 3
    ctl(2);
    wr(3'd4, 4'b0001, 32'hF);
    pulse(4'b1111);
    expect_none("R8 masked");
    rd(3'd5, r); chk(r == 32'hF, "R8 pending", 64'(r), 64'hF);
    wr(3'd4, 4'b0001, 32'h5);
    expect_msg(1, 32'hBEEC | 32'd1, "R9 replay first");
    expect_msg(3, 32'hBEEC | 32'd3, "R9 replay second");
    expect_none("R9 no extra");
    rd(3'd5, r); chk(r == 32'h5, "R9 pending left", 64'(r), 64'h5);

    // R6: shrinking count trims pending
    ctl(0);
    rd(3'd5, r); chk(r == 32'h1, "R6 trim", 64'(r), 64'h1);
    expect_none("R6 masked stays");
    ctl(2);
    wr(3'd4, 4'b0001, 32'h0);
    expect_msg(0, 32'hBEEC, "R9 replay v0");

    // R11: burst, lowest first, duplicate merged
    pulse(4'b1111);
    while (!msg_valid) @(negedge clk);
    pulse(4'b0001);
    for (int v = 0; v < NV; v++) expect_msg(v, 32'hBEEC | 32'(v), "R11 order");
    expect_none("R11 no duplicate");

    // R1: reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd0, r); chk(r == 32'h0184_0005, "R1 reset ctrl", 64'(r), 64'h0184_0005);
    rd(3'd1, r); chk(r == 0, "R1 reset addr", 64'(r), 0);
    rd(3'd3, r); chk(r == 0, "R1 reset data", 64'(r), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule